// File: doc/BRIEF.md
# Peripheral Bridge Control and Arbiter

This block lets three bus masters reach a shared peripheral bus: a local processor, a host port and a DMA engine. When the bridge is idle it arbitrates among their requests. A priority bit selects one of two fixed orders. The winner keeps its grant until its access completes or is aborted.

Each access runs in two timed phases. In the first phase the peripheral is selected with its strobe low. In the second phase the strobe is high. Each phase has a programmable minimum length. A down-counter limits how long the strobe may wait for the peripheral's acknowledge. If the wait runs out, the access is aborted with an error to the requester, an error pulse to the processor and a sticky error flag.

A 16-bit control word holds the phase lengths, the time-out, the priority bit, the error flag and the host-only mode indication. The processor reads and writes it, and reading it clears the error flag. The host reads a copy in which the error flag is hidden while host-only mode is active.

Top module: `pbus_bridge`

## Requirements
- R1: After reset the control word reads 0xFE4D, no grant is given and the select and strobe outputs are low.
- R2: With control bit 2 set, simultaneous requests are served processor (index 0), then host (index 1), then DMA (index 2).
- R3: With control bit 2 clear, the order is host, then DMA, then processor.
- R4: At most one grant is active at a time. A grant holds, and the peripheral address and data hold to the granted master's values, from the cycle after arbitration until the access ends. Arbitration happens only when the bridge is idle.
- R5: The first phase keeps the select high and the strobe low for N+1 cycles, where N is control bits 5:3. The strobe then rises.
- R6: Strobe cycles are numbered k = 0, 1, 2 and so on. The access completes in the first cycle k in which the acknowledge is high and k ≥ M, where M is control bits 8:6. In the following cycle the master sees a one-cycle done pulse with the captured read data, and its grant is dropped.
- R7: Let T be control bits 15:9. If no completion has happened by strobe cycle k = T, the access is aborted. The next cycle carries an error pulse to the master and a pulse on the processor error output. If completion and time-out fall in the same cycle, completion wins.
- R8: The error flag (bit 1) is set by a time-out or by a mode-change error pulse, and a processor read clears it. If a set and a read fall in the same cycle, the flag stays set. A mode-change error also pulses the processor error output.
- R9: Bit 0 follows the host-only mode input one cycle late and resets to 1. While it is 1, the host copy reads bit 1 as 0.
- R10: A processor write updates bits 15:2 only. Written values of bits 1:0 have no effect.
- R11: The host copy shows the same bits 15:2 as the processor copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mstReq | input | 3 | Access requests: processor, host, DMA |
| mstWe | input | 3 | Write enable per master |
| mstAddr | input | 3×AW | Address per master |
| mstWdata | input | 3×DW | Write data per master |
| mstGnt | output | 3 | One-hot grant |
| mstDone | output | 3 | Completion pulse per master |
| mstErr | output | 3 | Abort pulse per master |
| mstRdata | output | DW | Read data of the last completed access |
| perSel | output | 1 | Access in progress |
| perStrobe | output | 1 | Peripheral strobe |
| perWe | output | 1 | Peripheral write enable |
| perAddr | output | AW | Peripheral address |
| perWdata | output | DW | Peripheral write data |
| perRdata | input | DW | Peripheral read data |
| perAck | input | 1 | Peripheral acknowledge |
| hostOnly | input | 1 | Host-only mode state |
| modeErr | input | 1 | Mode-change error pulse |
| cpuRegRd | input | 1 | Processor read of control word (clears flag) |
| cpuRegWr | input | 1 | Processor write of control word |
| cpuRegWdata | input | 16 | Processor write data |
| cpuRegRdata | output | 16 | Processor view of control word |
| hostRegRdata | output | 16 | Host view of control word |
| cpuErrIrq | output | 1 | Error pulse to the processor |

## Verification
Two collisions matter. The first is an acknowledge that arrives in the strobe cycle where the time-out reaches zero. The bench provokes it by setting the time-out equal to the acknowledge latency, and a done pulse with no error pulse is the correct outcome. The second is a mode-change error pulse driven in the same cycle as a processor read of the control word. The flag must still read 1 afterwards and clear only on a later read. A behavioural model in the bench predicts every output cycle by cycle, so both outcomes are also compared on every clock.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  localparam int NUM_MST   = 3;
  localparam int IDX_CPU   = 0;
  localparam int IDX_HOST  = 1;
  localparam int IDX_DMA   = 2;
  localparam int REG_W     = 16;
  localparam int WS_W      = 3;
  localparam int TO_W      = 7;
  localparam int TO_LSB    = 9;
  localparam int HOLD_LSB  = 6;
  localparam int SETUP_LSB = 3;
  localparam int PRIO_BIT  = 2;
  localparam int FLAG_BIT  = 1;
  localparam int MODE_BIT  = 0;
  localparam int CFG_LSB   = 2;
  localparam logic [REG_W-1:0] REG_RESET = 16'hFE4D;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_FINISH = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;
    logic setupTick;
    logic enterStrobe;
    logic strobeTick;
    logic finishOk;
    logic finishTo;
  } ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic setupZero;
    logic holdZero;
    logic toZero;
  } stat_t;
endpackage

// File: rtl/pbb_arbiter.sv
module pbb_arbiter
  import pbb_pkg::*;
(
  input  logic [NUM_MST-1:0] req,
  input  logic               prioCpu,
  output logic [NUM_MST-1:0] pick
);
  // rank order per mode, highest first
  localparam int ORDER_CPU [NUM_MST] = '{IDX_CPU, IDX_HOST, IDX_DMA};
  localparam int ORDER_HST [NUM_MST] = '{IDX_HOST, IDX_DMA, IDX_CPU};

  always_comb begin
    pick = '0;
    for (int r = NUM_MST - 1; r >= 0; r--) begin
      if (prioCpu) begin
        if (req[ORDER_CPU[r]]) begin
          pick = '0;
          pick[ORDER_CPU[r]] = 1'b1;
        end
      end else begin
        if (req[ORDER_HST[r]]) begin
          pick = '0;
          pick[ORDER_HST[r]] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pbb_ctrl.sv
module pbb_ctrl
  import pbb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_MST-1:0] pick,
  input  logic               perAck,
  input  stat_t              statS,
  output ctrl_t              ctrlS,
  output logic [NUM_MST-1:0] mstGnt,
  output logic [NUM_MST-1:0] mstDone,
  output logic [NUM_MST-1:0] mstErr,
  output logic               perSel,
  output logic               perStrobe
);
  phase_t stateQ, stateD;
  logic [NUM_MST-1:0] gntQ, doneQ, errQ;
  logic busy;

  always_comb begin
    stateD = stateQ;
    ctrlS  = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (|pick) begin
          ctrlS.launch = 1'b1;
          stateD = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (statS.setupZero) begin
          ctrlS.enterStrobe = 1'b1;
          stateD = ST_STROBE;
        end else begin
          ctrlS.setupTick = 1'b1;
        end
      end
      ST_STROBE: begin
        if (perAck && statS.holdZero) begin
          ctrlS.finishOk = 1'b1;
          stateD = ST_FINISH;
        end else if (statS.toZero) begin
          ctrlS.finishTo = 1'b1;
          stateD = ST_FINISH;
        end else begin
          ctrlS.strobeTick = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      gntQ   <= '0;
      doneQ  <= '0;
      errQ   <= '0;
    end else begin
      stateQ <= stateD;
      if (ctrlS.launch) gntQ <= pick;
      else if (ctrlS.finishOk || ctrlS.finishTo) gntQ <= '0;
      doneQ <= ctrlS.finishOk ? gntQ : '0;
      errQ  <= ctrlS.finishTo ? gntQ : '0;
    end
  end

  assign busy      = (stateQ == ST_SETUP) || (stateQ == ST_STROBE);
  assign mstGnt    = gntQ;
  assign mstDone   = doneQ;
  assign mstErr    = errQ;
  assign perSel    = busy;
  assign perStrobe = (stateQ == ST_STROBE);

  p_gnt_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mstGnt));
  p_gnt_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(mstGnt));
  p_strobe_after_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perStrobe) |-> ($past(stateQ) == ST_SETUP));
  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !((|mstDone) && (|mstErr)));
endmodule

// File: rtl/pbb_datapath.sv
module pbb_datapath
  import pbb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_t                      ctrlS,
  input  logic [NUM_MST-1:0]         pick,
  input  logic [NUM_MST-1:0]         mstWe,
  input  logic [NUM_MST-1:0][AW-1:0] mstAddr,
  input  logic [NUM_MST-1:0][DW-1:0] mstWdata,
  input  logic [DW-1:0]              perRdata,
  input  logic                       hostOnly,
  input  logic                       modeErr,
  input  logic                       cpuRegRd,
  input  logic                       cpuRegWr,
  input  logic [REG_W-1:0]           cpuRegWdata,
  output stat_t                      statS,
  output logic                       prioCpu,
  output logic                       perWe,
  output logic [AW-1:0]              perAddr,
  output logic [DW-1:0]              perWdata,
  output logic [DW-1:0]              mstRdata,
  output logic [REG_W-1:0]           cpuRegRdata,
  output logic [REG_W-1:0]           hostRegRdata,
  output logic                       cpuErrIrq
);
  logic [REG_W-1:CFG_LSB] cfgQ;
  logic errFlagQ, modeQ, irqQ;
  logic [WS_W-1:0] setupCnt, holdCnt;
  logic [TO_W-1:0] toCnt;
  logic [AW-1:0] addrQ, addrSel;
  logic [DW-1:0] wdataQ, wdataSel, rdataQ;
  logic weQ, weSel;
  logic unusedWrLow;

  assign unusedWrLow = ^cpuRegWdata[CFG_LSB-1:0];

  // request mux over the one-hot pick
  always_comb begin
    addrSel  = '0;
    wdataSel = '0;
    weSel    = 1'b0;
    for (int m = 0; m < NUM_MST; m++) begin
      if (pick[m]) begin
        addrSel  = mstAddr[m];
        wdataSel = mstWdata[m];
        weSel    = mstWe[m];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      weQ    <= 1'b0;
      rdataQ <= '0;
    end else begin
      if (ctrlS.launch) begin
        addrQ  <= addrSel;
        wdataQ <= wdataSel;
        weQ    <= weSel;
      end
      if (ctrlS.finishOk) rdataQ <= perRdata;
    end
  end

  // phase and time-out counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupCnt <= '0;
      holdCnt  <= '0;
      toCnt    <= '0;
    end else begin
      if (ctrlS.launch) setupCnt <= cfgQ[SETUP_LSB +: WS_W];
      else if (ctrlS.setupTick) setupCnt <= setupCnt - 1'b1;
      if (ctrlS.enterStrobe) begin
        holdCnt <= cfgQ[HOLD_LSB +: WS_W];
        toCnt   <= cfgQ[TO_LSB +: TO_W];
      end else if (ctrlS.strobeTick) begin
        if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
        toCnt <= toCnt - 1'b1;
      end
    end
  end

  assign statS.setupZero = (setupCnt == '0);
  assign statS.holdZero  = (holdCnt == '0);
  assign statS.toZero    = (toCnt == '0);

  // control word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ     <= REG_RESET[REG_W-1:CFG_LSB];
      errFlagQ <= REG_RESET[FLAG_BIT];
      modeQ    <= REG_RESET[MODE_BIT];
      irqQ     <= 1'b0;
    end else begin
      if (cpuRegWr) cfgQ <= cpuRegWdata[REG_W-1:CFG_LSB];
      errFlagQ <= (errFlagQ && !cpuRegRd) || ctrlS.finishTo || modeErr;
      modeQ    <= hostOnly;
      irqQ     <= ctrlS.finishTo || modeErr;
    end
  end

  assign prioCpu      = cfgQ[PRIO_BIT];
  assign cpuRegRdata  = {cfgQ, errFlagQ, modeQ};
  assign hostRegRdata = {cfgQ, errFlagQ && !modeQ, modeQ};
  assign cpuErrIrq    = irqQ;
  assign perWe        = weQ;
  assign perAddr      = addrQ;
  assign perWdata     = wdataQ;
  assign mstRdata     = rdataQ;

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlS.finishTo || modeErr) |=> cpuRegRdata[FLAG_BIT]);
  p_mode_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (cpuRegRdata[MODE_BIT] == $past(hostOnly)));
  p_to_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.enterStrobe |=> (toCnt == $past(cfgQ[TO_LSB +: TO_W])));
  p_host_fields_r11: assert property (@(posedge clk) disable iff (!rstN)
    hostRegRdata[REG_W-1:CFG_LSB] == cpuRegRdata[REG_W-1:CFG_LSB]);
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_MST-1:0]         mstReq,
  input  logic [NUM_MST-1:0]         mstWe,
  input  logic [NUM_MST-1:0][AW-1:0] mstAddr,
  input  logic [NUM_MST-1:0][DW-1:0] mstWdata,
  output logic [NUM_MST-1:0]         mstGnt,
  output logic [NUM_MST-1:0]         mstDone,
  output logic [NUM_MST-1:0]         mstErr,
  output logic [DW-1:0]              mstRdata,
  output logic                       perSel,
  output logic                       perStrobe,
  output logic                       perWe,
  output logic [AW-1:0]              perAddr,
  output logic [DW-1:0]              perWdata,
  input  logic [DW-1:0]              perRdata,
  input  logic                       perAck,
  input  logic                       hostOnly,
  input  logic                       modeErr,
  input  logic                       cpuRegRd,
  input  logic                       cpuRegWr,
  input  logic [REG_W-1:0]           cpuRegWdata,
  output logic [REG_W-1:0]           cpuRegRdata,
  output logic [REG_W-1:0]           hostRegRdata,
  output logic                       cpuErrIrq
);
  logic [NUM_MST-1:0] pick;
  logic prioCpu;
  ctrl_t ctrlS;
  stat_t statS;

  pbb_arbiter u_arb (
    .req(mstReq), .prioCpu(prioCpu), .pick(pick)
  );

  pbb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pick(pick), .perAck(perAck), .statS(statS),
    .ctrlS(ctrlS), .mstGnt(mstGnt), .mstDone(mstDone), .mstErr(mstErr),
    .perSel(perSel), .perStrobe(perStrobe)
  );

  pbb_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlS(ctrlS), .pick(pick),
    .mstWe(mstWe), .mstAddr(mstAddr), .mstWdata(mstWdata),
    .perRdata(perRdata), .hostOnly(hostOnly), .modeErr(modeErr),
    .cpuRegRd(cpuRegRd), .cpuRegWr(cpuRegWr), .cpuRegWdata(cpuRegWdata),
    .statS(statS), .prioCpu(prioCpu), .perWe(perWe), .perAddr(perAddr),
    .perWdata(perWdata), .mstRdata(mstRdata), .cpuRegRdata(cpuRegRdata),
    .hostRegRdata(hostRegRdata), .cpuErrIrq(cpuErrIrq)
  );
endmodule

// File: tb/pbus_bridge_bench.sv
module pbus_bridge_bench;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic [2:0] mstReq, mstWe;
  logic [2:0][AW-1:0] mstAddr;
  logic [2:0][DW-1:0] mstWdata;
  logic [2:0] mstGnt, mstDone, mstErr;
  logic [DW-1:0] mstRdata, perRdata, perWdata;
  logic perSel, perStrobe, perWe, perAck;
  logic [AW-1:0] perAddr;
  logic hostOnly, modeErr, cpuRegRd, cpuRegWr, cpuErrIrq;
  logic [15:0] cpuRegWdata, cpuRegRdata, hostRegRdata;

  pbus_bridge #(.AW(AW), .DW(DW)) u_pbus_bridge (.*);

  int nRun = 0, nFail = 0, cyc = 0;
  bit ended = 0, modelOn = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  // behavioural reference
  int mPhase, mOwn, mCnt, mK;
  logic [2:0] mGnt, mDone, mErr;
  logic mIrq, mFlag, mMode;
  logic [15:2] mCfg;
  logic [15:0] mRdata;

  function automatic int pickOf(logic [2:0] r, logic cpuFirst);
    int ord[3];
    if (cpuFirst) ord = '{0, 1, 2}; else ord = '{1, 2, 0};
    foreach (ord[i]) if (r[ord[i]]) return ord[i];
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mGnt = 0; mDone = 0; mErr = 0; mIrq = 0;
      mFlag = 0; mMode = 1; mCfg = 14'h3F93; mRdata = 0;
    end else begin
      logic [2:0] nD, nE;
      logic toEv;
      nD = 0; nE = 0; toEv = 0;
      case (mPhase)
        0: if (|mstReq) begin
             mOwn = pickOf(mstReq, mCfg[2]); mGnt = 3'(1 << mOwn);
             mPhase = 1; mCnt = int'(mCfg[5:3]);
           end
        1: if (mCnt == 0) begin mPhase = 2; mK = 0; end else mCnt--;
        2: if (perAck && mK >= int'(mCfg[8:6])) begin
             nD[mOwn] = 1; mRdata = perRdata; mPhase = 3; mGnt = 0;
           end else if (mK == int'(mCfg[15:9])) begin
             nE[mOwn] = 1; toEv = 1; mPhase = 3; mGnt = 0;
           end else mK++;
        default: mPhase = 0;
      endcase
      mDone = nD; mErr = nE; mIrq = toEv || modeErr;
      mFlag = (mFlag && !cpuRegRd) || toEv || modeErr;
      mMode = hostOnly;
      if (cpuRegWr) mCfg = cpuRegWdata[15:2];
    end
  end

  // per-cycle compare, master and peripheral behaviour
  int ackLat = 0, sCnt = 0, setupCycles = 0, strobeCycles = 0, errCount = 0, doneCount = 0;
  int grantOrder[$];
  logic [2:0] prevGnt = 0;

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check("R4 grant", mstGnt, mGnt);
      check("R5 select", perSel, (mPhase == 1 || mPhase == 2));
      check("R5 strobe", perStrobe, (mPhase == 2));
      check("R6 done", mstDone, mDone);
      check("R7 error", mstErr, mErr);
      check("R7 irq", cpuErrIrq, mIrq);
      check("R8 cpu view", cpuRegRdata, {mCfg, mFlag, mMode});
      check("R9 host view", hostRegRdata, {mCfg, mFlag && !mMode, mMode});
      if (|mDone) check("R6 rdata", mstRdata, mRdata);
      if (mPhase == 1 || mPhase == 2) check("R4 address", perAddr, mstAddr[mOwn]);
    end
    if (mstGnt != 0 && prevGnt == 0) begin
      for (int m = 0; m < 3; m++) if (mstGnt[m]) grantOrder.push_back(m);
    end
    prevGnt = mstGnt;
    if (perSel && !perStrobe) setupCycles++;
    if (perStrobe) begin strobeCycles++; sCnt++; end else sCnt = 0;
    perAck = perStrobe && ackLat >= 0 && (sCnt - 1) >= ackLat;
    perRdata = 16'(perAddr * 7 + 3);
    for (int m = 0; m < 3; m++) begin
      if (mstDone[m]) doneCount++;
      if (mstErr[m]) errCount++;
      if (mstDone[m] || mstErr[m]) mstReq[m] = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  task automatic waitIdle();
    do @(negedge clk); while (mstReq != 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic writeCfg(logic [15:0] v);
    @(negedge clk); cpuRegWr = 1; cpuRegWdata = v;
    @(negedge clk); cpuRegWr = 0;
  endtask

  task automatic readReg();
    @(negedge clk); cpuRegRd = 1;
    @(negedge clk); cpuRegRd = 0;
  endtask

  initial begin
    rstN = 0; mstReq = 0; mstWe = 3'b010; perAck = 0; perRdata = 0;
    hostOnly = 1; modeErr = 0; cpuRegRd = 0; cpuRegWr = 0; cpuRegWdata = 0;
    for (int m = 0; m < 3; m++) begin
      mstAddr[m] = 8'(16 * m + 5); mstWdata[m] = 16'(16'h1000 * (m + 1));
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset word", cpuRegRdata, 16'hFE4D);
    check("R1 no grant", mstGnt, 0);
    check("R1 strobe low", {perSel, perStrobe}, 0);
    modelOn = 1;

    // R2: processor-first order
    ackLat = 0; grantOrder.delete();
    mstReq = 3'b111; waitIdle();
    check("R2 order size", grantOrder.size(), 3);
    if (grantOrder.size() == 3)
      check("R2 order", {grantOrder[0][3:0], grantOrder[1][3:0], grantOrder[2][3:0]}, 12'h012);

    // R3: host-first order
    writeCfg(16'hFE49); grantOrder.delete();
    mstReq = 3'b111; waitIdle();
    check("R3 order size", grantOrder.size(), 3);
    if (grantOrder.size() == 3)
      check("R3 order", {grantOrder[0][3:0], grantOrder[1][3:0], grantOrder[2][3:0]}, 12'h120);

    // R5/R6: setup 3, hold 0, ack latency 2
    writeCfg(16'hFE1C); ackLat = 2; setupCycles = 0; strobeCycles = 0; doneCount = 0;
    mstReq = 3'b001; waitIdle();
    check("R5 setup length", setupCycles, 4);
    check("R6 strobe length", strobeCycles, 3);
    check("R6 done count", doneCount, 1);

    // R6: hold 2 forces wait past an early ack
    writeCfg(16'hFE84); ackLat = 0; strobeCycles = 0;
    mstReq = 3'b100; waitIdle();
    check("R6 hold length", strobeCycles, 3);

    // R7: time-out 4, never acknowledged
    writeCfg(16'h0844); ackLat = -1; strobeCycles = 0; errCount = 0;
    mstReq = 3'b010; waitIdle();
    check("R7 timeout length", strobeCycles, 5);
    check("R7 error count", errCount, 1);
    hostOnly = 0; repeat (2) @(negedge clk);
    check("R8 flag set", cpuRegRdata[1], 1'b1);
    readReg(); @(negedge clk);
    check("R8 flag cleared", cpuRegRdata[1], 1'b0);

    // R7: ack on the time-out cycle, completion wins
    writeCfg(16'h0604); ackLat = 3; strobeCycles = 0; errCount = 0; doneCount = 0;
    mstReq = 3'b001; waitIdle();
    check("R7 tie done", doneCount, 1);
    check("R7 tie no error", errCount, 0);
    check("R7 tie flag", cpuRegRdata[1], 1'b0);

    // R8: set and read together
    @(negedge clk); modeErr = 1; cpuRegRd = 1;
    @(negedge clk); modeErr = 0; cpuRegRd = 0;
    check("R8 set wins", cpuRegRdata[1], 1'b1);
    readReg(); @(negedge clk);
    check("R8 later clear", cpuRegRdata[1], 1'b0);

    // R9: host mask
    @(negedge clk); modeErr = 1;
    @(negedge clk); modeErr = 0; hostOnly = 1;
    repeat (2) @(negedge clk);
    check("R9 host masked", hostRegRdata[1:0], 2'b01);
    check("R9 cpu sees flag", cpuRegRdata[1:0], 2'b11);
    hostOnly = 0; repeat (2) @(negedge clk);
    check("R9 host unmasked", hostRegRdata[1:0], 2'b10);
    readReg(); hostOnly = 1; repeat (2) @(negedge clk);

    // R10/R11: low bits not writable, host fields match
    writeCfg(16'hABCE); @(negedge clk);
    check("R10 write", cpuRegRdata, 16'hABCD);
    check("R11 host fields", hostRegRdata[15:2], cpuRegRdata[15:2]);
    check("R11 host word", hostRegRdata, 16'hABCD);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule